// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host 24 general-purpose I/O lines. The lines are arranged as two 8-bit ports, A and B, and one 8-bit port C. Port C is split into a high nibble (bits 7..4) and a low nibble (bits 3..0), and each nibble has its own direction. The host reaches the block through an 8-bit data bus with an active-low select, active-low read and write strobes and a 2-bit address. Each pin group has separate in, out and output-enable vectors, so a tristate pad can sit outside the block.

A single control register accepts two kinds of word. When bit 7 is 1, the word sets the direction of the four groups. When bit 7 is 0, the word sets or clears one chosen bit of port C and leaves everything else alone. Output data is held in latches. Input data is read straight from the pins at the moment of the read.

Top module: `pario_unit`

## Requirements
- R1: After reset, every output-enable vector is all zeros and every output latch holds 00h. A read of the control address (addr=3) returns 9Bh.
- R2: A write is taken only when cs_n=0 and wr_n=0 in the same cycle. The address picks the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. With cs_n=1, a write changes no output pin.
- R3: A data write to a port whose group is an output drives the written value on that group's out pins from the next cycle. The value then holds until the next write to that port.
- R4: A read of a port whose group is an input returns the present value of its in pins, with no latching.
- R5: A control write with bit 7 = 1 sets the group directions, where a 1 means input: bit 4 is port A, bit 3 is the high nibble of C, bit 1 is port B and bit 0 is the low nibble of C. 80h makes every group an output (all OE bits 1). 9Bh makes every group an input (all OE bits 0). The word is read back at addr=3.
- R6: The two nibbles of port C have independent directions. A read of port C returns the latch for an output nibble and the pins for an input nibble.
- R7: A control write with bit 7 = 0 writes bit 0 into port C latch bit number din[3:1]. The other port C bits and the ports A and B latches stay unchanged.
- R8: A bit set/reset write leaves every group's direction unchanged and leaves the control readback value unchanged.
- R9: A direction-setting write (bit 7 = 1) clears all output latches to zero.
- R10: A read of a port whose group is an output returns its latch value.
- R11: Raising rst at any time returns the block to the state given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Reset, active high, asynchronous |
| cs_n | input | 1 | Select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, 0 when not reading |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A latch output |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B latch output |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C latch output |
| pc_oe | output | 8 | Port C output enable |

## Verification
The direction words tried are all-output (80h), all-input (9Bh) and a mixed word with port A and low C as outputs and port B and high C as inputs. The mixed word separates the four direction bits from one another, and a port C read under it shows whether the two nibbles are muxed independently. Bit set/reset words that set a low-nibble bit and then clear a high-nibble bit show that only the chosen bit moves. Changing the input pins between two reads with no write in between shows that inputs are live and not latched. A write with select deasserted, and a reset raised in mid-run, show that the latches are protected and that reset returns the block to its starting state.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned NIB = DW / 2;
  localparam logic [DW-1:0] MODE_AT_RESET = 8'h9B;

  typedef enum logic [1:0] {SEL_A = 2'd0, SEL_B = 2'd1, SEL_C = 2'd2, SEL_CTRL = 2'd3} sel_e;

  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dirs_t;

  function automatic dirs_t dirs_of(input logic [DW-1:0] w);
    dirs_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  function automatic logic [DW-1:0] pick_half(input logic is_in, input logic [DW-1:0] pins,
                                              input logic [DW-1:0] lat);
    return is_in ? pins : lat;
  endfunction
endpackage

// File: rtl/ppio_bus_decode.sv
module ppio_bus_decode
  import ppio_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic       fmt_bit,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_mode,
  output logic       wr_bsr,
  output logic       rd_en
);
  logic wr_any;
  sel_e sel;

  assign sel    = sel_e'(addr);
  assign wr_any = !cs_n && !wr_n;
  assign rd_en  = !cs_n && !rd_n;

  always_comb begin
    wr_a    = 1'b0;
    wr_b    = 1'b0;
    wr_c    = 1'b0;
    wr_mode = 1'b0;
    wr_bsr  = 1'b0;
    if (wr_any) begin
      unique case (sel)
        SEL_A:    wr_a = 1'b1;
        SEL_B:    wr_b = 1'b1;
        SEL_C:    wr_c = 1'b1;
        SEL_CTRL: begin
          wr_mode = fmt_bit;
          wr_bsr  = !fmt_bit;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    assert_one_target_R2: assert ($countones({wr_a, wr_b, wr_c, wr_mode, wr_bsr}) <= 1)
      else $error("more than one write target");
  end
endmodule

// File: rtl/ppio_ctrl_reg.sv
module ppio_ctrl_reg
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mode,
  input  logic          wr_bsr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] mode_q,
  output dirs_t         dirs
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          mode_q <= MODE_AT_RESET;
    else if (wr_mode) mode_q <= din;
  end

  assign dirs = dirs_of(mode_q);

  assert_bsr_keeps_mode_R8: assert property (@(posedge clk) disable iff (rst)
    wr_bsr |=> $stable(mode_q)) else $error("bit write altered mode");

  assert_mode_loads_R5: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> mode_q == $past(din)) else $error("mode word not captured");
endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
  parameter int unsigned W   = 8,
  parameter int unsigned LSB = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_full,
  input  logic [W-1:0] wdata,
  input  logic         bsr_en,
  input  logic [2:0]   bsr_idx,
  input  logic         bsr_val,
  output logic [W-1:0] q
);
  logic [W-1:0] bit_hit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_hit[i] = bsr_en && (32'(bsr_idx) == LSB + i);
    always_ff @(posedge clk or posedge rst) begin
      if (rst)             q[i] <= 1'b0;
      else if (clr)        q[i] <= 1'b0;
      else if (wr_full)    q[i] <= wdata[i];
      else if (bit_hit[i]) q[i] <= bsr_val;
    end
  end

  assert_clear_on_mode_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0) else $error("latch not cleared");

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(clr || wr_full || bsr_en) |=> $stable(q)) else $error("latch moved while idle");
endmodule

// File: rtl/pario_unit.sv
module pario_unit
  import ppio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic wr_a, wr_b, wr_c, wr_mode, wr_bsr, rd_en;
  logic [DW-1:0] mode_q;
  dirs_t dirs;
  logic [NIB-1:0] lat_cu, lat_cl;
  logic [DW-1:0] rd_mux;

  ppio_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .fmt_bit(din[DW-1]),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_mode(wr_mode), .wr_bsr(wr_bsr),
    .rd_en(rd_en)
  );

  ppio_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_bsr(wr_bsr), .din(din),
    .mode_q(mode_q), .dirs(dirs)
  );

  ppio_latch #(.W(DW), .LSB(0)) u_la (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_full(wr_a), .wdata(din),
    .bsr_en(1'b0), .bsr_idx(din[3:1]), .bsr_val(din[0]), .q(pa_out)
  );

  ppio_latch #(.W(DW), .LSB(0)) u_lb (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_full(wr_b), .wdata(din),
    .bsr_en(1'b0), .bsr_idx(din[3:1]), .bsr_val(din[0]), .q(pb_out)
  );

  ppio_latch #(.W(NIB), .LSB(NIB)) u_lcu (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_full(wr_c), .wdata(din[DW-1:NIB]),
    .bsr_en(wr_bsr), .bsr_idx(din[3:1]), .bsr_val(din[0]), .q(lat_cu)
  );

  ppio_latch #(.W(NIB), .LSB(0)) u_lcl (
    .clk(clk), .rst(rst), .clr(wr_mode), .wr_full(wr_c), .wdata(din[NIB-1:0]),
    .bsr_en(wr_bsr), .bsr_idx(din[3:1]), .bsr_val(din[0]), .q(lat_cl)
  );

  assign pc_out = {lat_cu, lat_cl};
  assign pa_oe  = {DW{!dirs.a_in}};
  assign pb_oe  = {DW{!dirs.b_in}};
  assign pc_oe  = {{NIB{!dirs.cu_in}}, {NIB{!dirs.cl_in}}};

  always_comb begin
    unique case (sel_e'(addr))
      SEL_A:    rd_mux = pick_half(dirs.a_in, pa_in, pa_out);
      SEL_B:    rd_mux = pick_half(dirs.b_in, pb_in, pb_out);
      SEL_C:    rd_mux = {pick_half(dirs.cu_in, pc_in, pc_out)[DW-1:NIB],
                          pick_half(dirs.cl_in, pc_in, pc_out)[NIB-1:0]};
      SEL_CTRL: rd_mux = mode_q;
      default:  rd_mux = '0;
    endcase
  end

  assign dout = rd_en ? rd_mux : '0;

  assert_bsr_spares_ab_R7: assert property (@(posedge clk) disable iff (rst)
    wr_bsr |=> $stable(pa_out) && $stable(pb_out)) else $error("bit write touched A/B");

  assert_bsr_target_R7: assert property (@(posedge clk) disable iff (rst)
    wr_bsr |=> pc_out[$past(din[3:1])] == $past(din[0])) else $error("bit write missed");

  assert_bsr_keeps_dir_R8: assert property (@(posedge clk) disable iff (rst)
    wr_bsr |=> $stable(pc_oe) && $stable(pa_oe) && $stable(pb_oe)) else $error("direction moved");

  assert_deselected_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)) else $error("write while deselected");
endmodule

// File: tb/tb_pario_unit.sv
module tb_pario_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pario_unit dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  // monitor: pops the expected read value for each read strobe seen
  always @(posedge clk) begin
    if (!cs_n && !rd_n && exp_q.size() > 0) begin
      check(dout, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic reset_state_checks(input string tag);
    check(pa_oe, 8'h00, tag);
    check(pb_oe, 8'h00, tag);
    check(pc_oe, 8'h00, tag);
    check(pa_out | pb_out | pc_out, 8'h00, tag);
    bus_rd(2'd3, 8'h9B, tag);
  endtask

  initial begin
    #(20 * 5000);
    bad++; total++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_state_checks("R1");

    // R5: all outputs
    bus_wr(2'd3, 8'h80, 1'b0);
    check(pa_oe, 8'hFF, "R5 A oe");
    check(pb_oe, 8'hFF, "R5 B oe");
    check(pc_oe, 8'hFF, "R5 C oe");
    bus_rd(2'd3, 8'h80, "R5 readback");

    // R3 / R10: latched outputs
    bus_wr(2'd0, 8'h5A, 1'b0);
    bus_wr(2'd1, 8'hC3, 1'b0);
    bus_wr(2'd2, 8'hF0, 1'b0);
    check(pa_out, 8'h5A, "R3 A");
    check(pb_out, 8'hC3, "R3 B");
    check(pc_out, 8'hF0, "R3 C");
    pa_in = 8'h11;
    bus_rd(2'd0, 8'h5A, "R10 A");
    bus_rd(2'd1, 8'hC3, "R10 B");

    // R2: deselected write ignored
    bus_wr(2'd0, 8'h11, 1'b1);
    check(pa_out, 8'h5A, "R2 deselected");

    // R7 / R8: bit set/reset
    bus_wr(2'd3, 8'h07, 1'b0);
    check(pc_out, 8'hF8, "R7 set bit3");
    bus_wr(2'd3, 8'h0E, 1'b0);
    check(pc_out, 8'h78, "R7 clear bit7");
    check(pa_out, 8'h5A, "R7 A kept");
    check(pb_out, 8'hC3, "R7 B kept");
    check(pc_oe, 8'hFF, "R8 C oe kept");
    bus_rd(2'd3, 8'h80, "R8 readback");

    // R9 / R5 / R4: all inputs
    bus_wr(2'd3, 8'h9B, 1'b0);
    check(pa_out | pb_out | pc_out, 8'h00, "R9 cleared");
    check(pa_oe | pb_oe | pc_oe, 8'h00, "R5 all in");
    pa_in = 8'h3C;
    bus_rd(2'd0, 8'h3C, "R4 A first");
    pa_in = 8'h99;
    bus_rd(2'd0, 8'h99, "R4 A live");
    pb_in = 8'h42;
    bus_rd(2'd1, 8'h42, "R4 B");

    // R6: mixed directions (A out, B in, C high in, C low out)
    bus_wr(2'd3, 8'h8A, 1'b0);
    check(pa_oe, 8'hFF, "R6 A oe");
    check(pb_oe, 8'h00, "R6 B oe");
    check(pc_oe, 8'h0F, "R6 C oe");
    bus_wr(2'd2, 8'hA5, 1'b0);
    check(pc_out, 8'hA5, "R6 C latch");
    pc_in = 8'h3C;
    bus_rd(2'd2, 8'h35, "R6 C mixed read");
    bus_wr(2'd3, 8'h81, 1'b0);
    check(pc_oe, 8'hF0, "R6 C low in");
    bus_rd(2'd2, 8'h0C, "R6 C mixed read 2");

    // R11: reset mid-run
    bus_wr(2'd0, 8'h77, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    reset_state_checks("R11");

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule